// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for each beat of a short burst access to a synchronous memory. An address strobe captures a starting address. That address comes from either the processor-side request or the cache-controller-side request. The low bits of the captured address set the first burst position. On each later clock edge where the advance input is high, the sequencer moves to the next burst position. The upper address bits stay unchanged for the whole burst.

A static order-select input picks the visiting order of the burst positions:

- **Interleaved order:** the low bits are the start bits XOR the beat count. This is the order some processors use for cache-line fills.
- **Linear order:** the low bits are the start bits plus the beat count, wrapping within the burst.

After the last beat the position returns to the start. On the memory side, the first beat of an access costs the strobe cycle plus the access cycle, and each later beat costs one cycle. A parameter can drop either order at build time.

Top module: `burst_addr_gen`

## Requirements
- R1: With `rst` high at a rising edge, the next value of `addr_out` is all zeros, whatever the strobe and advance inputs are doing at that edge.
- R2: At a rising edge where a strobe is high and `rst` is low, `addr_in` is captured, and `addr_out` equals `addr_in` from the next cycle on (beat count zero in both orders).
- R3: Either strobe alone, `strobe_proc` or `strobe_ctrl`, loads the address exactly as both together do.
- R4: At a rising edge with `advance` high and no strobe, the beat count increases by one, modulo 2^BEAT_BITS (four beats by default).
- R5: At a rising edge with no strobe and `advance` low, `addr_out` keeps its value.
- R6: With `order_sel` = 1 (interleaved), `addr_out[BEAT_BITS-1:0]` equals the captured start bits XOR the beat count. For example, start 01 gives 01, 00, 11, 10.
- R7: With `order_sel` = 0 (linear), `addr_out[BEAT_BITS-1:0]` equals the start bits plus the beat count, modulo 2^BEAT_BITS. For example, start 01 gives 01, 10, 11, 00.
- R8: After four advances the low bits return to the captured start bits.
- R9: A strobe at the same edge as `advance` reloads the address and clears the beat count; the advance has no effect.
- R10: Bits `addr_out[ADDR_W-1:BEAT_BITS]` change only on a load or a reset. A linear wrap never carries into them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_proc | input | 1 | Processor-side address strobe |
| strobe_ctrl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step to the next burst position |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| addr_in | input | ADDR_W | Start address presented with a strobe |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Two situations are hardest to reach from the ports:

- **A strobe colliding with an advance in the middle of a burst.** Here the reload has to win and the count has to restart.
- **A linear wrap under an all-ones upper field.** Here a carry leaking upward would show.

The bench sweeps every start position in both orders with each strobe source. It uses upper fields of all zeros, all ones and a mixed pattern. It inserts holds between advances, and it ends some bursts with a strobe-plus-advance edge that carries a different address.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Build-time choice of which burst orderings are implemented.
   typedef enum int {
      SEQ_BOTH             = 0,
      SEQ_LINEAR_ONLY      = 1,
      SEQ_INTERLEAVED_ONLY = 2
   } seq_variant_e;

   // Encoding of the order-select input.
   localparam logic ORD_LINEAR      = 1'b0;
   localparam logic ORD_INTERLEAVED = 1'b1;

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q
);

   always_ff @(posedge clk) begin
      if (rst)
         base_q <= '0;
      else if (load)
         base_q <= addr_in;
   end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
   parameter int BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic                 step,
   output logic [BEAT_BITS-1:0] count_q
);

   localparam logic [BEAT_BITS-1:0] ONE = BEAT_BITS'(1);

   // A load outranks a step; the counter wraps naturally at its width.
   always_ff @(posedge clk) begin
      if (rst)
         count_q <= '0;
      else if (load)
         count_q <= '0;
      else if (step)
         count_q <= count_q + ONE;
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int BEAT_BITS = 2,
   parameter seq_variant_e VARIANT = SEQ_BOTH
) (
   input  logic [BEAT_BITS-1:0] start_bits,
   input  logic [BEAT_BITS-1:0] count,
   input  logic                 order_sel,
   output logic [BEAT_BITS-1:0] pos
);

   logic [BEAT_BITS-1:0] lin_pos;
   logic [BEAT_BITS-1:0] ilv_pos;

   assign lin_pos = start_bits + count;
   assign ilv_pos = start_bits ^ count;

   generate
      if (VARIANT == SEQ_BOTH) begin : g_both
         assign pos = (order_sel == ORD_INTERLEAVED) ? ilv_pos : lin_pos;
      end else if (VARIANT == SEQ_LINEAR_ONLY) begin : g_lin
         logic unused_ok;
         assign unused_ok = order_sel ^ (|ilv_pos);
         assign pos = lin_pos;
      end else begin : g_ilv
         logic unused_ok;
         assign unused_ok = order_sel ^ (|lin_pos);
         assign pos = ilv_pos;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int BEAT_BITS = 2,
   parameter seq_variant_e VARIANT = SEQ_BOTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_proc,
   input  logic              strobe_ctrl,
   input  logic              advance,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int UPPER_W = ADDR_W - BEAT_BITS;

   generate
      if (BEAT_BITS < 1) begin : g_err_beat
         $error("burst_addr_gen: BEAT_BITS must be at least 1");
      end
      if (UPPER_W < 1) begin : g_err_width
         $error("burst_addr_gen: ADDR_W must exceed BEAT_BITS");
      end
   endgenerate

   logic                 load;
   logic [ADDR_W-1:0]    base_q;
   logic [BEAT_BITS-1:0] count_q;
   logic [BEAT_BITS-1:0] pos;

   assign load = strobe_proc | strobe_ctrl;

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .addr_in (addr_in),
      .base_q  (base_q)
   );

   burst_beat_counter #(.BEAT_BITS(BEAT_BITS)) u_count (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (advance),
      .count_q (count_q)
   );

   burst_order_map #(.BEAT_BITS(BEAT_BITS), .VARIANT(VARIANT)) u_map (
      .start_bits (base_q[BEAT_BITS-1:0]),
      .count      (count_q),
      .order_sel  (order_sel),
      .pos        (pos)
   );

   assign addr_out = {base_q[ADDR_W-1:BEAT_BITS], pos};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 17,
   parameter int BEAT_BITS = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              strobe_proc,
   input logic              strobe_ctrl,
   input logic              advance,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out
);

   logic any_strobe;
   assign any_strobe = strobe_proc | strobe_ctrl;

   // R1: reset drives the address to zero
   a_r1_reset_zero: assert property (@(posedge clk)
      rst |=> addr_out == '0);

   // R2, R3, R9: any strobe loads the presented address
   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      any_strobe |=> addr_out == $past(addr_in));

   // R5: no strobe and no advance holds the address
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!any_strobe && !advance) |=>
         ($stable(addr_out) || !$stable(order_sel)));

   // R10: upper bits move only on a load
   a_r10_upper_fixed: assert property (@(posedge clk) disable iff (rst)
      !any_strobe |=>
         addr_out[ADDR_W-1:BEAT_BITS] == $past(addr_out[ADDR_W-1:BEAT_BITS]));

   // R7, R4: in linear order an advance steps the low bits by one
   a_r7_linear_step: assert property (@(posedge clk) disable iff (rst)
      (advance && !any_strobe && order_sel == 1'b0) |=>
         (order_sel != 1'b0) ||
         (addr_out[BEAT_BITS-1:0] ==
          BEAT_BITS'($past(addr_out[BEAT_BITS-1:0]) + 1'b1)));

   // R6, R4: in interleaved order an advance always changes the low bits
   a_r6_ilv_moves: assert property (@(posedge clk) disable iff (rst)
      (advance && !any_strobe && order_sel == 1'b1) |=>
         (order_sel != 1'b1) || !$stable(addr_out[BEAT_BITS-1:0]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
   .ADDR_W    (ADDR_W),
   .BEAT_BITS (BEAT_BITS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .strobe_proc (strobe_proc),
   .strobe_ctrl (strobe_ctrl),
   .advance     (advance),
   .order_sel   (order_sel),
   .addr_in     (addr_in),
   .addr_out    (addr_out)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

   localparam int AW = 8;
   localparam int BB = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          strobe_proc, strobe_ctrl, advance, order_sel;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_BITS(BB)) uut (
      .clk(clk), .rst(rst), .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
      .advance(advance), .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
   );

   function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s,
                                          input logic [1:0] c);
      if (m) return s ^ c;          // interleaved
      return 2'(s + c);             // linear
   endfunction

   task automatic check(input string req, input logic [AW-1:0] exp);
      vectors++;
      if (addr_out !== exp) begin
         miscompares++;
         $display("FAIL %s: addr_out=%h expected %h", req, addr_out, exp);
      end
   endtask

   // Drive inputs now (just after a falling edge), then wait one full cycle.
   task automatic cyc(input logic r, input logic sp, input logic sc,
                      input logic adv, input logic [AW-1:0] a);
      rst = r; strobe_proc = sp; strobe_ctrl = sc; advance = adv; addr_in = a;
      @(negedge clk);
   endtask

   initial begin
      rst = 1'b1; strobe_proc = 0; strobe_ctrl = 0; advance = 0;
      order_sel = 0; addr_in = '0;
      @(negedge clk);
      cyc(1, 0, 0, 0, 8'h00);
      check("R1 reset state", 8'h00);

      for (int m = 0; m < 2; m++) begin
         order_sel = m[0];
         for (int src = 1; src < 4; src++) begin
            for (int u = 0; u < 3; u++) begin
               for (int s = 0; s < 4; s++) begin
                  logic [5:0] up;
                  logic [1:0] c;
                  up = (u == 0) ? 6'h00 : (u == 1) ? 6'h3F : 6'h2A;
                  cyc(0, src[0], src[1], 0, {up, s[1:0]});
                  check("R2 R3 load", {up, s[1:0]});
                  c = 2'd0;
                  for (int b = 0; b < 4; b++) begin
                     cyc(0, 0, 0, 1, ~{up, s[1:0]});
                     c = c + 2'd1;
                     check(m ? "R4 R6 R10 interleaved step" : "R4 R7 R10 linear step",
                           {up, exp_low(m[0], s[1:0], c)});
                     if (b == 1) begin
                        cyc(0, 0, 0, 0, 8'h55);
                        check("R5 hold", {up, exp_low(m[0], s[1:0], c)});
                     end
                  end
                  check("R8 wrap to start", {up, s[1:0]});
                  // mid-burst reload beats advance
                  cyc(0, 0, 0, 1, 8'h00);
                  cyc(0, src[0], src[1], 1, {~up, ~s[1:0]});
                  check("R9 strobe over advance", {~up, ~s[1:0]});
               end
            end
         end
      end

      // reset outranks a strobe
      cyc(1, 1, 1, 1, 8'hC3);
      check("R1 reset over strobe", 8'h00);
      cyc(0, 0, 0, 1, 8'h00);
      check("R1 count cleared by reset", 8'h01);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule